// File: doc/BRIEF.md
# Serial and Keyboard Overrun Status Latch

This block keeps the sticky error flags of a serial/keyboard I/O controller. Three conditions are recorded. A serial receive overrun occurs when a new received byte arrives while the serial-receive interrupt is still pending. A keyboard overrun occurs when a new key code arrives while the keyboard interrupt is still pending. A framing error occurs when the receiver strobes one. Each flag stays set until software writes to a separate clear register. The write data does not matter: the strobe alone clears.

The flags are read through an 8-bit status port in active-low form. The interrupt-status vector uses the same active-low convention and the same bit positions as the status port: bit 5 is the serial receive interrupt and bit 6 is the keyboard interrupt. A pending interrupt therefore shows as a 0 in exactly the bit that its overrun flag occupies. The shift register and the keyboard scanner sit outside this block and only supply strobes.

Top module: `ovr_status_latch`

## Requirements
- R1: While rst_i is high at a clock edge, all three flags clear, so status_o reads 8'hFF after that edge.
- R2: If rx_stb_i is high while irq_stat_n_i[5] is 0 (serial interrupt pending), status_o[5] reads 0 after that clock edge.
- R3: If key_stb_i is high while irq_stat_n_i[6] is 0 (keyboard interrupt pending), status_o[6] reads 0 after that clock edge.
- R4: An event strobe has no effect when its own interrupt bit is 1 (not pending). The pending state of the other interrupt bit also has no effect on it.
- R5: If frm_err_stb_i is high, status_o[7] reads 0 after that clock edge, whatever the interrupt bits are.
- R6: Once a flag reads 0, it keeps reading 0 until a clear write occurs. Interrupt bits returning to 1 and further strobes do not change it.
- R7: A cycle with clr_wr_i high and no new set condition returns status_o[7:5] to 1 after that edge.
- R8: When a clear write and a set condition for a flag fall in the same cycle, that flag reads 0 after the edge. Flags without a set condition are cleared.
- R9: status_o[4:0] always read 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| rx_stb_i | input | 1 | One-cycle strobe: new serial byte received |
| key_stb_i | input | 1 | One-cycle strobe: new keyboard code |
| frm_err_stb_i | input | 1 | One-cycle strobe: serial framing error |
| irq_stat_n_i | input | 8 | Interrupt status, active low (bit 5 serial receive, bit 6 keyboard) |
| clr_wr_i | input | 1 | Write strobe to the clear register; clears all flags |
| status_o | output | 8 | Active-low status: bit 7 framing, bit 6 keyboard overrun, bit 5 serial overrun, bits 4..0 read 1 |

## Verification
The hardest case to reach is a clear write that lands in the same cycle as a qualifying event, with an unrelated flag already set. This case separates "set wins" from "clear wins" and from "clear only the quiet flags". The stimulus first sets one flag. It then issues a clear together with a strobe whose interrupt bit is held pending, and it also repeats this pairing for every flag combination. Random cycles add to this by driving clears and strobes at high density with pending bits biased toward 0, so that same-cycle collisions occur often.

// File: rtl/ovr_pkg.sv
`timescale 1ns/1ps
package ovr_pkg;
  localparam int STAT_W      = 8;
  localparam int SER_BIT     = 5;
  localparam int KEY_BIT     = 6;
  localparam int FRM_BIT     = 7;
  localparam int NUM_FLAGS   = 3;
  // index of each sticky flag inside the internal flag vector
  localparam int IDX_SER     = 0;
  localparam int IDX_KEY     = 1;
  localparam int IDX_FRM     = 2;
endpackage

// File: rtl/ovr_event_gate.sv
`timescale 1ns/1ps
module ovr_event_gate
  import ovr_pkg::*;
#(
  parameter int W      = STAT_W,
  parameter int S_BIT  = SER_BIT,
  parameter int K_BIT  = KEY_BIT,
  parameter int NF     = NUM_FLAGS
) (
  input  logic         rx_stb_i,
  input  logic         key_stb_i,
  input  logic         frm_stb_i,
  input  logic [W-1:0] irq_n_i,
  output logic [NF-1:0] set_o
);
  logic unused_irq_bits;
  assign unused_irq_bits = ^irq_n_i;

  always_comb begin
    set_o          = '0;
    // an overrun only counts while the matching interrupt is still pending (low)
    set_o[IDX_SER] = rx_stb_i  & ~irq_n_i[S_BIT];
    set_o[IDX_KEY] = key_stb_i & ~irq_n_i[K_BIT];
    set_o[IDX_FRM] = frm_stb_i;
  end
endmodule

// File: rtl/ovr_sticky.sv
`timescale 1ns/1ps
module ovr_sticky (
  input  logic clk_i,
  input  logic rst_i,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_q
);
  always_ff @(posedge clk_i) begin
    if (rst_i)      flag_q <= 1'b0;
    else if (set_i) flag_q <= 1'b1;   // new event beats a same-cycle clear
    else if (clr_i) flag_q <= 1'b0;
  end

  // R1: reset clears the flag
  assert_reset_clears_R1: assert property (@(posedge clk_i) rst_i |=> !flag_q);
  // R8: set has priority over clear
  assert_set_wins_R8: assert property (@(posedge clk_i) disable iff (rst_i)
    set_i |=> flag_q);
  // R7: clear without set empties the flag
  assert_clear_R7: assert property (@(posedge clk_i) disable iff (rst_i)
    (clr_i && !set_i) |=> !flag_q);
  // R6: quiet cycles hold the flag
  assert_hold_R6: assert property (@(posedge clk_i) disable iff (rst_i)
    (!clr_i && !set_i) |=> $stable(flag_q));
endmodule

// File: rtl/ovr_status_pack.sv
`timescale 1ns/1ps
module ovr_status_pack
  import ovr_pkg::*;
#(
  parameter int W     = STAT_W,
  parameter int S_BIT = SER_BIT,
  parameter int K_BIT = KEY_BIT,
  parameter int F_BIT = FRM_BIT,
  parameter int NF    = NUM_FLAGS
) (
  input  logic [NF-1:0] flags_i,
  output logic [W-1:0]  status_o
);
  always_comb begin
    status_o        = '1;             // unused positions read as 1
    status_o[S_BIT] = ~flags_i[IDX_SER];
    status_o[K_BIT] = ~flags_i[IDX_KEY];
    status_o[F_BIT] = ~flags_i[IDX_FRM];
  end
endmodule

// File: rtl/ovr_status_latch.sv
`timescale 1ns/1ps
module ovr_status_latch
  import ovr_pkg::*;
#(
  parameter int W     = STAT_W,
  parameter int S_BIT = SER_BIT,
  parameter int K_BIT = KEY_BIT,
  parameter int F_BIT = FRM_BIT
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  logic         rx_stb_i,
  input  logic         key_stb_i,
  input  logic         frm_err_stb_i,
  input  logic [W-1:0] irq_stat_n_i,
  input  logic         clr_wr_i,
  output logic [W-1:0] status_o
);
  localparam int NF = NUM_FLAGS;

  logic [NF-1:0] set_req;
  logic [NF-1:0] flags_q;

  ovr_event_gate #(.W(W), .S_BIT(S_BIT), .K_BIT(K_BIT), .NF(NF)) u_gate (
    .rx_stb_i  (rx_stb_i),
    .key_stb_i (key_stb_i),
    .frm_stb_i (frm_err_stb_i),
    .irq_n_i   (irq_stat_n_i),
    .set_o     (set_req)
  );

  for (genvar g = 0; g < NF; g++) begin : g_flag
    ovr_sticky u_flag (
      .clk_i  (clk_i),
      .rst_i  (rst_i),
      .set_i  (set_req[g]),
      .clr_i  (clr_wr_i),
      .flag_q (flags_q[g])
    );
  end

  ovr_status_pack #(.W(W), .S_BIT(S_BIT), .K_BIT(K_BIT), .F_BIT(F_BIT), .NF(NF)) u_pack (
    .flags_i  (flags_q),
    .status_o (status_o)
  );

  // R2: serial event during pending serial interrupt
  assert_ser_ovr_R2: assert property (@(posedge clk_i) disable iff (rst_i)
    (rx_stb_i && !irq_stat_n_i[S_BIT]) |=> !status_o[S_BIT]);
  // R3: keyboard event during pending keyboard interrupt
  assert_key_ovr_R3: assert property (@(posedge clk_i) disable iff (rst_i)
    (key_stb_i && !irq_stat_n_i[K_BIT]) |=> !status_o[K_BIT]);
  // R4: event with its interrupt idle leaves a clear bit clear
  assert_ser_idle_R4: assert property (@(posedge clk_i) disable iff (rst_i)
    (status_o[S_BIT] && !(rx_stb_i && !irq_stat_n_i[S_BIT])) |=> status_o[S_BIT]);
  // R5: framing strobe
  assert_frame_R5: assert property (@(posedge clk_i) disable iff (rst_i)
    frm_err_stb_i |=> !status_o[F_BIT]);
  // R6: a set serial bit survives until a clear write
  assert_sticky_R6: assert property (@(posedge clk_i) disable iff (rst_i)
    (!clr_wr_i && !status_o[S_BIT]) |=> !status_o[S_BIT]);
  // R7: clear write with no keyboard set condition
  assert_key_clear_R7: assert property (@(posedge clk_i) disable iff (rst_i)
    (clr_wr_i && !key_stb_i) |=> status_o[K_BIT]);
endmodule

// File: tb/tb_ovr_status_latch.sv
`timescale 1ns/1ps
module tb_ovr_status_latch;
  logic       clk = 1'b0;
  logic       rst;
  logic       rx_stb, key_stb, frm_stb, clr_wr;
  logic [7:0] irq_n;
  logic [7:0] status;
  int         checks = 0;
  int         errors = 0;
  bit         done = 0;
  logic [2:0] mdl;   // {frm,key,ser} model flags

  always #5 clk = ~clk;

  ovr_status_latch dut (
    .clk_i(clk), .rst_i(rst), .rx_stb_i(rx_stb), .key_stb_i(key_stb),
    .frm_err_stb_i(frm_stb), .irq_stat_n_i(irq_n), .clr_wr_i(clr_wr),
    .status_o(status)
  );

  function automatic logic [2:0] next_flags(logic [2:0] f, logic rx, logic ky,
                                            logic fe, logic clr, logic [7:0] irq);
    logic [2:0] s;
    s = {fe, ky & ~irq[6], rx & ~irq[5]};
    return (clr ? 3'b000 : f) | s;
  endfunction

  function automatic logic [7:0] exp_status(logic [2:0] f);
    return {~f[2], ~f[1], ~f[0], 5'b11111};
  endfunction

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive at negedge, let one posedge pass, compare at the next negedge
  task automatic cyc(logic rx, logic ky, logic fe, logic clr, logic [7:0] irq);
    rx_stb = rx; key_stb = ky; frm_stb = fe; clr_wr = clr; irq_n = irq;
    mdl = next_flags(mdl, rx, ky, fe, clr, irq);
    @(negedge clk);
  endtask

  task automatic chk_all(string tag);
    logic [7:0] e;
    e = exp_status(mdl);
    chk({tag, " R2 ser"}, {7'b0, status[5]}, {7'b0, e[5]});
    chk({tag, " R3 key"}, {7'b0, status[6]}, {7'b0, e[6]});
    chk({tag, " R5 frm"}, {7'b0, status[7]}, {7'b0, e[7]});
    chk({tag, " R9 low"}, {3'b0, status[4:0]}, 8'h1F);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = $urandom(32'h5EED);
    rst = 1; rx_stb = 0; key_stb = 0; frm_stb = 0; clr_wr = 0; irq_n = 8'hFF;
    mdl = 3'b000;
    @(negedge clk); @(negedge clk);
    chk("R1 reset", status, 8'hFF);
    rst = 0;

    // R4: strobes with their interrupts idle, other bit pending
    cyc(1, 0, 0, 0, 8'hBF);   // rx with only keyboard pending
    chk("R4 rx idle", status, 8'hFF);
    cyc(0, 1, 0, 0, 8'hDF);   // key with only serial pending
    chk("R4 key idle", status, 8'hFF);
    // R2 then R6: set, then release interrupts; flag must stay
    cyc(1, 0, 0, 0, 8'hDF);
    chk("R2 set", status, 8'hDF);
    cyc(0, 0, 0, 0, 8'hFF);
    cyc(1, 1, 0, 0, 8'hFF);
    chk("R6 sticky", status, 8'hDF);
    // R3 and R5
    cyc(0, 1, 0, 0, 8'hBF);
    chk("R3 set", status, 8'h9F);
    cyc(0, 0, 1, 0, 8'hFF);
    chk("R5 set", status, 8'h1F);
    // R7 clear
    cyc(0, 0, 0, 1, 8'h00);
    chk("R7 clear", status, 8'hFF);
    // R8 collisions: each flag set with clear while others were set
    for (int k = 0; k < 3; k++) begin
      cyc(1, 1, 1, 0, 8'h00);
      cyc(k == 0, k == 1, k == 2, 1, 8'h9F);
      chk("R8 set wins", status, exp_status(mdl));
    end
    cyc(0, 0, 0, 1, 8'hFF);
    // random phase
    for (int i = 0; i < 3000; i++) begin
      logic [7:0] irq;
      irq = 8'($urandom);
      if ($urandom_range(3) != 0) irq[5] = 1'b0;
      if ($urandom_range(3) != 0) irq[6] = 1'b0;
      cyc(1'($urandom_range(1)), 1'($urandom_range(1)),
          $urandom_range(7) == 0, $urandom_range(3) == 0, irq);
      chk_all("rand");
      if (i == 1500) begin
        rst = 1; @(negedge clk); rst = 0; mdl = 3'b000;
        chk("R1 mid reset", status, 8'hFF);
      end
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule